// File: doc/BRIEF.md
# Mask Compress Index Generator

This block converts a per-element predicate mask into a packed list of element positions and a new element count. A 64-lane mask, usually produced by comparing two vectors lane by lane for equality, is offered together with the current vector length. Only lanes below that length take part. The block then streams out the position of every participating lane whose mask bit is set, one position per cycle. After the last position it presents the number of such lanes. That number becomes the vector length for a later gather, compute and scatter sequence, and the positions serve as the gather and scatter addresses.

There are three valid/ready handshakes. A transfer takes place on a rising clock edge when valid and ready are both high. The mask input is ready only while the block is idle. Once a mask is taken, input ready stays low until the count has been handed off. The position and count outputs hold valid and their data steady while their ready is low, so a consumer can stall either one for any number of cycles without losing or reordering data.

Top module: `mcx_mask_compress`

## Requirements
- R1: After reset, `in_ready` is 1 and both `idx_valid` and `cnt_valid` are 0.
- R2: `idx_data` carries the element position (0 to 63) of each set, participating mask bit. Each position appears exactly once, in strictly increasing order.
- R3: Mask bit i takes part only when i < `in_vlen`. Bits at or above the vector length emit no position and are not counted. A length of 64 or more means all 64 lanes take part.
- R4: `cnt_data` equals the number of participating set bits (0 to 64). It is presented only after the last position has been handed off, and never in the same cycle as a position.
- R5: A mask with no participating set bits emits no positions and presents a count of 0 in the cycle after it is accepted.
- R6: `in_ready` is 0 from the cycle after a mask is accepted until the cycle after its count is handed off. It is 0 whenever `idx_valid` or `cnt_valid` is 1.
- R7: While `idx_valid` is 1 and `idx_ready` is 0, `idx_valid` and `idx_data` stay the same in the next cycle. The count output behaves the same way under `cnt_ready`.
- R8: With both readies held high, positions are issued back to back, one per cycle, starting the cycle after acceptance. The count follows in the cycle after the last position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Mask and length offered |
| in_ready | output | 1 | Block idle and accepting a mask |
| in_mask | input | 64 | Predicate mask, bit i for lane i |
| in_vlen | input | 7 | Current vector length |
| idx_valid | output | 1 | Position output valid |
| idx_ready | input | 1 | Consumer accepts a position |
| idx_data | output | 6 | Lane position of a set mask bit |
| cnt_valid | output | 1 | Count output valid |
| cnt_ready | input | 1 | Consumer accepts the count |
| cnt_data | output | 7 | Number of participating set bits |

## Verification
A wrong pending-lane register shows up as a missing, repeated or out-of-order position. When positions come back to back, this is visible at the very next position handshake. A wrong stored count is visible only later, when the count output appears after the final position. A wrong state register shows up as `in_ready` high while the block is busy, or as a stalled output that changes. Either one appears within one cycle of the faulty transition.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EMIT  = 2'd1,
    ST_COUNT = 2'd2
  } mcx_state_e;
endpackage

// File: rtl/mcx_len_mask.sv
module mcx_len_mask #(
  parameter int LANES = 64,
  parameter int CW    = 7
) (
  input  logic [LANES-1:0] mask,
  input  logic [CW-1:0]    vlen,
  output logic [LANES-1:0] kept
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign kept[g] = mask[g] & (vlen > CW'(g));
  end
endmodule

// File: rtl/mcx_lowest.sv
module mcx_lowest #(
  parameter int LANES = 64,
  parameter int IW    = 6
) (
  input  logic [LANES-1:0] vec,
  output logic             found,
  output logic [IW-1:0]    pos
);
  always_comb begin
    pos = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (vec[i]) pos = IW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/mcx_popcount.sv
module mcx_popcount #(
  parameter int LANES = 64,
  parameter int CW    = 7
) (
  input  logic [LANES-1:0] vec,
  output logic [CW-1:0]    ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < LANES; i++) begin
      ones = ones + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/mcx_mask_compress.sv
module mcx_mask_compress
  import mcx_pkg::*;
#(
  parameter int LANES = 64,
  parameter int IW    = $clog2(LANES),
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LANES-1:0] in_mask,
  input  logic [CW-1:0]    in_vlen,
  output logic             idx_valid,
  input  logic             idx_ready,
  output logic [IW-1:0]    idx_data,
  output logic             cnt_valid,
  input  logic             cnt_ready,
  output logic [CW-1:0]    cnt_data
);
  mcx_state_e       state;
  logic [LANES-1:0] pending;
  logic [CW-1:0]    total;

  logic [LANES-1:0] kept;
  logic [CW-1:0]    kept_ones;
  logic             any_left;
  logic [IW-1:0]    low_pos;
  logic [LANES-1:0] pending_next;

  mcx_len_mask #(.LANES(LANES), .CW(CW)) u_len (
    .mask (in_mask),
    .vlen (in_vlen),
    .kept (kept)
  );

  mcx_popcount #(.LANES(LANES), .CW(CW)) u_pop (
    .vec  (kept),
    .ones (kept_ones)
  );

  mcx_lowest #(.LANES(LANES), .IW(IW)) u_low (
    .vec   (pending),
    .found (any_left),
    .pos   (low_pos)
  );

  assign pending_next = pending & ~(LANES'(1) << low_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= '0;
      total   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          pending <= kept;
          total   <= kept_ones;
          state   <= (|kept) ? ST_EMIT : ST_COUNT;
        end
        ST_EMIT: if (idx_ready) begin
          pending <= pending_next;
          if (pending_next == '0) state <= ST_COUNT;
        end
        ST_COUNT: if (cnt_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign idx_valid = (state == ST_EMIT) && any_left;
  assign idx_data  = low_pos;
  assign cnt_valid = (state == ST_COUNT);
  assign cnt_data  = total;
endmodule

// File: rtl/mcx_mask_compress_chk.sv
module mcx_mask_compress_chk #(
  parameter int LANES = 64,
  parameter int IW    = 6,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          idx_valid,
  input logic          idx_ready,
  input logic [IW-1:0] idx_data,
  input logic          cnt_valid,
  input logic          cnt_ready,
  input logic [CW-1:0] cnt_data
);
  p_busy_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid || cnt_valid) |-> !in_ready);

  p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !idx_ready) |=> (idx_valid && $stable(idx_data)));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !cnt_ready) |=> (cnt_valid && $stable(cnt_data)));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_valid && cnt_valid));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> (cnt_data <= CW'(LANES)));

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_ready) |=> (!idx_valid || (idx_data > $past(idx_data))));

  p_count_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_ready) |=> (idx_valid || cnt_valid));
endmodule

bind mcx_mask_compress mcx_mask_compress_chk #(
  .LANES(LANES), .IW(IW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .idx_valid (idx_valid),
  .idx_ready (idx_ready),
  .idx_data  (idx_data),
  .cnt_valid (cnt_valid),
  .cnt_ready (cnt_ready),
  .cnt_data  (cnt_data)
);

// File: tb/mcx_mask_compress_tb.sv
module mcx_mask_compress_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_mask = '0;
  logic [6:0]  in_vlen = '0;
  logic        idx_valid;
  logic        idx_ready = 1'b0;
  logic [5:0]  idx_data;
  logic        cnt_valid;
  logic        cnt_ready = 1'b0;
  logic [6:0]  cnt_data;

  int checks = 0;
  int bad = 0;
  int exp_pos[64];
  int exp_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcx_mask_compress u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask), .in_vlen(in_vlen),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_data(cnt_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_expect(input logic [63:0] m, input int vl);
    exp_n = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i] && i < vl) begin
        exp_pos[exp_n] = i;
        exp_n++;
      end
    end
  endtask

  // mode 0: readies always high; mode 1: readies low every third cycle
  task automatic run_case(input logic [63:0] m, input int vl, input int mode, input string tag);
    int k = 0;
    int cyc = 0;
    bit done = 0;
    bit stalled = 0;
    int held = 0;
    int last_pos_cyc = -1;
    bit r;
    build_expect(m, vl);
    @(negedge clk);
    check(in_ready === 1'b1, {tag, " R6 idle ready"}, int'(in_ready), 1);
    in_mask  = m;
    in_vlen  = 7'(vl);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_mask  = '0;
    while (!done && cyc < 400) begin
      r = (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
      idx_ready = r;
      cnt_ready = r;
      if (in_ready !== 1'b0) check(0, {tag, " R6 busy ready"}, int'(in_ready), 0);
      if (stalled) check(idx_valid === 1'b1 && int'(idx_data) == held,
                         {tag, " R7 hold"}, int'(idx_data), held);
      stalled = 0;
      if (idx_valid) begin
        if (cnt_valid) check(0, {tag, " R4 overlap"}, 1, 0);
        if (r) begin
          if (k < exp_n)
            check(int'(idx_data) == exp_pos[k], {tag, " R2 position"}, int'(idx_data), exp_pos[k]);
          else
            check(0, {tag, " R3 extra position"}, int'(idx_data), -1);
          if (mode == 0 && k == 0)
            check(cyc == 0, {tag, " R8 first position cycle"}, cyc, 0);
          last_pos_cyc = cyc;
          k++;
        end else begin
          stalled = 1;
          held = int'(idx_data);
        end
      end else if (cnt_valid) begin
        check(k == exp_n, {tag, " R4 all positions first"}, k, exp_n);
        check(int'(cnt_data) == exp_n, {tag, " R4 count"}, int'(cnt_data), exp_n);
        if (mode == 0)
          check(cyc == last_pos_cyc + 1, {tag, " R8 count timing"}, cyc, last_pos_cyc + 1);
        if (r) done = 1;
      end
      cyc++;
      if (!done) @(negedge clk);
    end
    check(done, {tag, " R4 count seen"}, int'(done), 1);
    @(negedge clk);
    idx_ready = 1'b0;
    cnt_ready = 1'b0;
    check(in_ready === 1'b1, {tag, " R6 ready after count"}, int'(in_ready), 1);
  endtask

  task automatic t_reset();
    check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(idx_valid === 1'b0, "R1 idx_valid", int'(idx_valid), 0);
    check(cnt_valid === 1'b0, "R1 cnt_valid", int'(cnt_valid), 0);
  endtask

  task automatic t_sparse();      run_case(64'h8000_0100_0040_0005, 64, 0, "sparse R2"); endtask
  task automatic t_backpressure(); run_case(64'hF0F0_1234_8888_0F01, 64, 1, "stall R7"); endtask
  task automatic t_vlen_clip();   run_case(64'hFFFF_0000_00FF_FF0F, 20, 0, "clip R3"); endtask
  task automatic t_vlen_over();   run_case(64'hA000_0000_0000_0003, 100, 0, "over R3"); endtask
  task automatic t_empty();       run_case(64'h0, 64, 0, "empty R5"); endtask
  task automatic t_hidden_only(); run_case(64'hFFFF_FFFF_FFFF_FF00, 8, 0, "hidden R5"); endtask
  task automatic t_full();        run_case('1, 64, 1, "full R4"); endtask
  task automatic t_zero_len();    run_case('1, 0, 0, "zerolen R3"); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sparse();
    t_backpressure();
    t_vlen_clip();
    t_vlen_over();
    t_empty();
    t_hidden_only();
    t_full();
    t_zero_len();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog R4: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule